// File: doc/BRIEF.md
# Prescaled UART Baud Generator

This block produces the 16x oversampling strobe that a UART's transmitter and receiver step on. The strobe is a single-cycle pulse on `tick`, qualified by the system clock `clk`. Its rate comes from two divider stages. A fixed halving stage feeds a power-of-four prescaler, which divides by 1, 4, 16 or 64. That prescaler feeds an 8-bit divisor. The fastest strobe is therefore half the clock rate.

A source selector picks one of four paths:
- the internal clock fed straight through;
- the internal clock through the divider chain;
- an external serial clock fed straight through;
- the external serial clock through the divider chain.

The external clock is sampled through a two-flop synchroniser. Its rising edge is used as a clock enable, so the block has only one clock domain.

Configuration is loaded through a write strobe with three fields: divisor, prescale code and source code. Every write restarts the divider chain, so the first strobe after a write already follows the new settings. Out of reset, the divider is preloaded for 9600 baud at the clock rate given by `CLK_HZ`. The preload is worked out when the design is built: halve the quotient, then take the smallest prescale whose scaled value fits in 8 bits, and saturate to divisor 255 with prescale 64 if none fits.

Top module: `baud_prescaler`

## Requirements
- R1: During reset and in the cycle after it, `tick` is 0. After reset the block runs the internal-clock-through-divider source with the 9600-baud preload. At the default 7.3728 MHz clock this preload is divisor 24 with prescale code 0, giving one tick every 48 cycles.
- R2: With source code 01, `tick` pulses once every 2·P·N clock cycles. P is 1, 4, 16 or 64 for prescale codes 00, 01, 10 and 11. N is the divisor value.
- R3: A divisor value of 0 counts as 256, so code 00 with divisor 0 ticks every 512 cycles.
- R4: The cycle after a write, `tick` is 0, even if that cycle would have produced a strobe. The first tick after a write comes exactly 2·P·N enables after it.
- R5: With source code 00 and no write, `tick` is 1 in every cycle.
- R6: With source code 10, each rising edge of `ext_sclk` produces exactly one tick cycle. The tick appears after the third rising clock edge that samples the new high level.
- R7: With source code 11, the divider counts synchronised rising edges of `ext_sclk` instead of clock cycles. It ticks after every 2·P·N such edges.
- R8: In the divided modes (codes 01 and 11), `tick` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads the three configuration fields and restarts the divider |
| cfg_div | input | 8 | Divisor, 0 meaning 256 |
| cfg_pre | input | 2 | Prescale code: 00 /1, 01 /4, 10 /16, 11 /64 |
| cfg_src | input | 2 | Source code: 00 internal direct, 01 internal divided, 10 external direct, 11 external divided |
| ext_sclk | input | 1 | External serial clock, asynchronous |
| tick | output | 1 | One-cycle 16x oversampling strobe |

## Verification
The configuration write and the divider's terminal count can fall in the same cycle, and so can a write and an external edge that is in flight through the synchroniser. The bench provokes the first case by issuing a second write exactly 2·P·N enables after the previous one, the very cycle the strobe would fire. It checks that no strobe appears and that the count restarts from zero. The cycle-level model gives the write priority over the count, and every clock cycle `tick` is compared against that model.

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int CLK_HZ     = 7372800,
  parameter int RESET_BAUD = 9600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_div,
  input  logic [1:0] cfg_pre,
  input  logic [1:0] cfg_src,
  input  logic       ext_sclk,
  output logic       tick
);

  function automatic logic [9:0] preload(input int hz, input int baud);
    logic [31:0] q;
    logic [31:0] s;
    q = 32'(hz / (16 * baud)) >> 1;
    if (q < 32'd256) begin
      s = q;
      return {2'd0, s[7:0]};
    end else if (q < 32'd1024) begin
      s = q >> 2;
      return {2'd1, s[7:0]};
    end else if (q < 32'd4096) begin
      s = q >> 4;
      return {2'd2, s[7:0]};
    end else if (q < 32'd16384) begin
      s = q >> 6;
      return {2'd3, s[7:0]};
    end
    return {2'd3, 8'hFF};
  endfunction

  localparam logic [9:0] RST_CFG = preload(CLK_HZ, RESET_BAUD);

  logic [7:0] div_q;
  logic [1:0] pre_q, src_q;
  logic       s1, s2, s3;
  logic       h_q;
  logic [5:0] pc_q;
  logic [7:0] dc_q;
  logic       tick_q;

  logic       rise, en, last;
  logic [5:0] pmax;
  logic [7:0] dmax;

  assign rise = s2 & ~s3;
  assign en   = src_q[1] ? rise : 1'b1;
  assign pmax = 6'(7'd1 << {pre_q, 1'b0}) - 6'd1;
  assign dmax = div_q - 8'd1;
  assign last = h_q && (pc_q == pmax) && (dc_q == dmax);
  assign tick = tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= ext_sclk;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= RST_CFG[7:0];
      pre_q  <= RST_CFG[9:8];
      src_q  <= 2'b01;
      h_q    <= 1'b0;
      pc_q   <= '0;
      dc_q   <= '0;
      tick_q <= 1'b0;
    end else if (cfg_we) begin
      div_q  <= cfg_div;
      pre_q  <= cfg_pre;
      src_q  <= cfg_src;
      h_q    <= 1'b0;
      pc_q   <= '0;
      dc_q   <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= src_q[0] ? (en && last) : en;
      if (src_q[0] && en) begin
        h_q <= ~h_q;
        if (h_q) begin
          pc_q <= (pc_q == pmax) ? 6'd0 : pc_q + 6'd1;
          if (pc_q == pmax)
            dc_q <= (dc_q == dmax) ? 8'd0 : dc_q + 8'd1;
        end
      end
    end
  end

  AST_GEN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && src_q[0]) |-> (dc_q == 8'd0 && pc_q == 6'd0 && !h_q)); // R2

  AST_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !tick); // R4

  AST_INT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && src_q == 2'b00) |=> tick); // R5

  AST_EXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && src_q == 2'b10) |-> $past(s2 && !s3)); // R6

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && src_q[0]) |=> !tick); // R8

endmodule

// File: tb/baud_prescaler_bench.sv
`timescale 1ns/1ps
module baud_prescaler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_div = '0;
  logic [1:0] cfg_pre = '0;
  logic [1:0] cfg_src = '0;
  logic       ext_sclk = 1'b0;
  logic       tick;

  always #4 clk = ~clk;

  baud_prescaler u_baud_prescaler (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
    .cfg_pre(cfg_pre), .cfg_src(cfg_src), .ext_sclk(ext_sclk), .tick(tick)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string req = "R1";
  int    gcy = 0;
  int    ext_per = 0;

  int mdiv = (7372800 / (16 * 9600)) / 2;
  int mpre = 0;
  int msrc = 1;
  int cnt  = 0;
  bit x1 = 0, x2 = 0, x3 = 0;
  bit exp_t;

  function automatic int period(int d, int p);
    return 2 * (1 << (2 * p)) * ((d == 0) ? 256 : d);
  endfunction

  function automatic bit ext_level();
    if (ext_per == 0) return 1'b0;
    return (gcy % ext_per) < (ext_per / 2);
  endfunction

  task automatic check(bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: tick actual %0b expected %0b", req, gcy, act, exp);
    end
  endtask

  task automatic cyc(bit we, logic [7:0] d, logic [1:0] p, logic [1:0] s);
    bit x, rise, en;
    x = ext_level();
    cfg_we = we; cfg_div = d; cfg_pre = p; cfg_src = s; ext_sclk = x;
    rise = x2 & ~x3;
    if (we) begin
      mdiv = d; mpre = p; msrc = s; cnt = 0; exp_t = 0;
    end else if (msrc == 0) exp_t = 1;
    else if (msrc == 2) exp_t = rise;
    else begin
      en = (msrc == 3) ? rise : 1'b1;
      exp_t = 0;
      if (en) begin
        cnt++;
        if (cnt == period(mdiv, mpre)) begin exp_t = 1; cnt = 0; end
      end
    end
    x3 = x2; x2 = x1; x1 = x;
    @(posedge clk); #1;
    check(tick, exp_t);
    gcy++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'd0, 2'd0, 2'd0);
  endtask

  task automatic wr(logic [7:0] d, logic [1:0] p, logic [1:0] s);
    cyc(1'b1, d, p, s);
  endtask

  initial begin
    #(100000 * 8);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 req = "R1"; check(tick, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    req = "R1"; idle(200);
    req = "R2"; wr(8'd3, 2'd0, 2'b01); idle(30);
    req = "R2"; wr(8'd1, 2'd1, 2'b01); idle(40);
    req = "R2"; wr(8'd2, 2'd2, 2'b01); idle(200);
    req = "R2"; wr(8'd1, 2'd3, 2'b01); idle(400);
    req = "R3"; wr(8'd0, 2'd0, 2'b01); idle(1100);
    req = "R4"; wr(8'd10, 2'd0, 2'b01); idle(13);
    wr(8'd3, 2'd0, 2'b01); idle(30);
    req = "R4"; wr(8'd10, 2'd0, 2'b01); idle(19);
    wr(8'd10, 2'd0, 2'b01); idle(45);
    req = "R5"; wr(8'd5, 2'd1, 2'b00); idle(20);
    ext_per = 6;
    req = "R6"; wr(8'd5, 2'd0, 2'b10); idle(60);
    req = "R7"; wr(8'd2, 2'd0, 2'b11); idle(150);
    req = "R8"; wr(8'd1, 2'd0, 2'b01); idle(20);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule